// File: doc/BRIEF.md
# Indexed Display Controller Register Port

This block is the control register file that a host uses to program a simple framebuffer display controller. The host first writes a register number into the index port. Later reads and writes on the value port act on the selected register. Most registers have side effects that other blocks of the controller see. Writes to the version code, the enable bit, the colour depth and the command-queue configuration are checked before they take effect. A write to the mode size raises a redraw request. A sync write raises a drain request towards the command processor. Writes to the cursor visibility produce an update pulse for the cursor overlay.

The block also holds the advertised limits and the colour masks. These are derived at build time from the host colour depth. It also holds a small array of general-purpose scratch words and reports accesses to register numbers that it does not implement. The command-queue header words (lower bound, upper bound, next and stop pointers) come in on input pins from the shared queue memory. The block checks them when the host declares the queue configured.

Top module: `dispctl_regport`

## Requirements
- R1: A write with `req_sel`=0 loads the 32-bit index register, and a read with `req_sel`=0 returns it. A value-port access (`req_sel`=1) acts on the register named by the index. Every read returns its data with `rsp_valid` high exactly one cycle after the request, and `req_ready` is always high.
- R2: Index 0 holds the version code and resets to 0x90000002. A write is stored only when the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the register unchanged.
- R3: A write to index 1 stores the value, which reads back unchanged, and `enable_o` is high while the value is nonzero. A zero value also clears `cfg_valid_o`, and a nonzero value leaves it unchanged. Every such write gives a one-cycle `invalidate_o` pulse.
- R4: A nonzero write to index 1 latches the framebuffer size ceil(depth/8) × width × height. This size reads back at index 16.
- R5: Indices 2 and 3 store the requested width and height, read them back, and give a one-cycle `invalidate_o` pulse on write. Index 12 reads ceil(depth/8) × width.
- R6: The read-only values are as follows. Index 4 reads 2360 and index 5 reads 1770. Index 6 reads the depth. Indices 7 and 28 read the depth rounded up to a multiple of 8. Indices 9/10/11 read the red/green/blue masks (depth 32: 0xFF0000/0xFF00/0xFF). Index 17 reads the capability word (default 0x3). Index 29 reads the scratch word count (default 16). Writes to these indices change nothing.
- R7: A write to index 6 or 7 whose value differs from the depth clears `cfg_valid_o`. A matching value has no effect.
- R8: A nonzero write to index 20 sets `cfg_valid_o` only if all four queue words are multiples of 4, the lower bound is at least 16, the upper bound is at most 0x10000, and the upper bound is at least the lower bound + 10240. If a check fails, the flag keeps its previous value. A zero write clears the flag. Index 20 reads the flag as bit 0.
- R9: A write to index 21 sets the busy flag and gives a one-cycle `sync_req_o` pulse. Indices 21 and 22 both read the busy flag, and a `sync_done` pulse clears it.
- R10: Indices 24, 25 and 26 store the cursor id, X and Y. On index 27, value 1 sets `cursor_vis_o` and value 0 clears it, and only these two codes give a one-cycle `cursor_upd_o` pulse. Codes 2 and 3, or any other value, leave the bit unchanged. Index 27 reads the bit.
- R11: Indices 1792 to 1792+SCRATCH_N-1 form a read/write scratch array of 32-bit words.
- R12: The following indices read zero and ignore writes: 8, 30, 31, 32 and 1024–1791. Any other unimplemented index reads zero and gives a one-cycle `bad_access_o` pulse in the cycle after the access, aligned with any read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = index port, 1 = value port |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| q_lo | input | 32 | Queue lower bound word (bytes) |
| q_hi | input | 32 | Queue upper bound word (bytes) |
| q_next | input | 32 | Queue producer pointer word |
| q_stop | input | 32 | Queue consumer pointer word |
| sync_done | input | 1 | Command processor finished draining |
| enable_o | output | 1 | Controller enabled |
| cfg_valid_o | output | 1 | Queue configuration accepted |
| invalidate_o | output | 1 | Full redraw request pulse |
| sync_req_o | output | 1 | Drain request pulse |
| cursor_vis_o | output | 1 | Cursor visible |
| cursor_upd_o | output | 1 | Cursor state update pulse |
| cursor_x_o | output | 32 | Cursor X position |
| cursor_y_o | output | 32 | Cursor Y position |
| fb_size_o | output | 32 | Latched framebuffer size in bytes |
| bad_access_o | output | 1 | Unimplemented index access pulse |

## Verification
The hardest case to reach is a configuration commit that fails validation. Such a commit must leave an already accepted configuration in place. The bench first commits a legal set of queue words. It then changes one header word at a time on the pins to break a single rule: alignment, the lower-bound floor, the upper-bound ceiling, or the minimum span. It recommits after each change and checks that the flag keeps its value. The exact boundary values are committed as well, to show they are accepted. The cursor visibility codes 2 and 3 are written after both a show and a hide, to prove they leave the bit and the update pulse alone.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam logic [31:0] IX_VER     = 32'd0;
  localparam logic [31:0] IX_EN      = 32'd1;
  localparam logic [31:0] IX_WID     = 32'd2;
  localparam logic [31:0] IX_HGT     = 32'd3;
  localparam logic [31:0] IX_MAXW    = 32'd4;
  localparam logic [31:0] IX_MAXH    = 32'd5;
  localparam logic [31:0] IX_DEPTH   = 32'd6;
  localparam logic [31:0] IX_BPP     = 32'd7;
  localparam logic [31:0] IX_PSEUDO  = 32'd8;
  localparam logic [31:0] IX_RMASK   = 32'd9;
  localparam logic [31:0] IX_GMASK   = 32'd10;
  localparam logic [31:0] IX_BMASK   = 32'd11;
  localparam logic [31:0] IX_PITCH   = 32'd12;
  localparam logic [31:0] IX_FBSIZE  = 32'd16;
  localparam logic [31:0] IX_CAPS    = 32'd17;
  localparam logic [31:0] IX_CFG     = 32'd20;
  localparam logic [31:0] IX_SYNC    = 32'd21;
  localparam logic [31:0] IX_BUSY    = 32'd22;
  localparam logic [31:0] IX_CUR_ID  = 32'd24;
  localparam logic [31:0] IX_CUR_X   = 32'd25;
  localparam logic [31:0] IX_CUR_Y   = 32'd26;
  localparam logic [31:0] IX_CUR_ON  = 32'd27;
  localparam logic [31:0] IX_HOSTBPP = 32'd28;
  localparam logic [31:0] IX_SCRSZ   = 32'd29;
  localparam logic [31:0] IX_MEMREGS = 32'd30;
  localparam logic [31:0] IX_NDISP   = 32'd31;
  localparam logic [31:0] IX_PLOCK   = 32'd32;
  localparam logic [31:0] IX_PAL_LO  = 32'd1024;
  localparam logic [31:0] IX_PAL_HI  = 32'd1791;
  localparam logic [31:0] IX_SCR_BASE = 32'd1792;

  localparam logic [31:0] VER_BASE   = 32'h9000_0000;
  localparam logic [31:0] VER_TOP    = 32'h9000_0002;

  function automatic logic [31:0] red_mask(input int d);
    case (d)
      8:       return 32'h0000_0007;
      15, 16:  return 32'h0000_001F;
      default: return 32'h00FF_0000;
    endcase
  endfunction

  function automatic logic [31:0] green_mask(input int d);
    case (d)
      8:       return 32'h0000_0038;
      15:      return 32'h0000_03E0;
      16:      return 32'h0000_07E0;
      default: return 32'h0000_FF00;
    endcase
  endfunction

  function automatic logic [31:0] blue_mask(input int d);
    case (d)
      8:       return 32'h0000_00C0;
      15:      return 32'h0000_7C00;
      16:      return 32'h0000_F800;
      default: return 32'h0000_00FF;
    endcase
  endfunction
endpackage

// File: rtl/dispctl_qcheck.sv
module dispctl_qcheck #(
  parameter int HDR_BYTES   = 16,
  parameter int QUEUE_BYTES = 65536,
  parameter int MIN_SPAN    = 10240
) (
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  input  logic [31:0] nxt,
  input  logic [31:0] stp,
  output logic        ok
);
  logic aligned, floor_ok, ceil_ok, span_ok;
  always_comb begin
    aligned  = ((lo | hi | nxt | stp) & 32'd3) == 32'd0;
    floor_ok = lo >= 32'(HDR_BYTES);
    ceil_ok  = hi <= 32'(QUEUE_BYTES);
    span_ok  = {1'b0, hi} >= ({1'b0, lo} + 33'(MIN_SPAN));
    ok       = aligned & floor_ok & ceil_ok & span_ok;
  end
endmodule

// File: rtl/dispctl_scratch.sv
module dispctl_scratch #(
  parameter int WORDS = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dispctl_regport.sv
module dispctl_regport
  import dispctl_pkg::*;
#(
  parameter int          COLOR_DEPTH = 32,
  parameter int          SCRATCH_N   = 16,
  parameter int          MAX_W       = 2360,
  parameter int          MAX_H       = 1770,
  parameter int          QUEUE_BYTES = 65536,
  parameter int          MIN_SPAN    = 10240,
  parameter logic [31:0] CAPS        = 32'h0000_0003
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_sel,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic [31:0] q_lo,
  input  logic [31:0] q_hi,
  input  logic [31:0] q_next,
  input  logic [31:0] q_stop,
  input  logic        sync_done,
  output logic        enable_o,
  output logic        cfg_valid_o,
  output logic        invalidate_o,
  output logic        sync_req_o,
  output logic        cursor_vis_o,
  output logic        cursor_upd_o,
  output logic [31:0] cursor_x_o,
  output logic [31:0] cursor_y_o,
  output logic [31:0] fb_size_o,
  output logic        bad_access_o
);
  localparam int          SCR_AW   = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;
  localparam int          BYTES_PP = (COLOR_DEPTH + 7) / 8;
  localparam logic [31:0] BPP_RND  = 32'(BYTES_PP * 8);
  localparam logic [31:0] SCR_END  = IX_SCR_BASE + 32'(SCRATCH_N);
  localparam int          HDR_BYTES = 16;

  logic [31:0] idx_q, ver_q, en_q, wid_q, hgt_q, fb_q;
  logic [31:0] cur_id_q, cur_x_q, cur_y_q;
  logic        cfg_q, busy_q, vis_q;
  logic        inval_q, sync_q, cupd_q, bad_q;
  logic        rsp_v_q, rsp_scr_q;
  logic [31:0] rsp_buf_q, scr_rd;

  logic wr_val, rd_val, wr_idx, rd_idx;
  logic in_scr, known, q_ok;
  logic [SCR_AW-1:0] scr_off;
  logic [31:0] rdc, pitch;

  assign wr_val = req_valid &  req_write &  req_sel;
  assign rd_val = req_valid & ~req_write &  req_sel;
  assign wr_idx = req_valid &  req_write & ~req_sel;
  assign rd_idx = req_valid & ~req_write & ~req_sel;

  assign in_scr  = (idx_q >= IX_SCR_BASE) && (idx_q < SCR_END);
  assign scr_off = SCR_AW'(idx_q - IX_SCR_BASE);
  assign pitch   = 32'(BYTES_PP) * wid_q;

  dispctl_qcheck #(
    .HDR_BYTES(HDR_BYTES), .QUEUE_BYTES(QUEUE_BYTES), .MIN_SPAN(MIN_SPAN)
  ) u_qcheck (
    .lo(q_lo), .hi(q_hi), .nxt(q_next), .stp(q_stop), .ok(q_ok)
  );

  dispctl_scratch #(.WORDS(SCRATCH_N), .AW(SCR_AW)) u_scratch (
    .clk(clk), .we(wr_val & in_scr), .waddr(scr_off), .wdata(req_wdata),
    .raddr(scr_off), .rdata(scr_rd)
  );

  // Read decode of the selected index
  always_comb begin
    rdc   = '0;
    known = 1'b1;
    case (idx_q)
      IX_VER:                       rdc = ver_q;
      IX_EN:                        rdc = en_q;
      IX_WID:                       rdc = wid_q;
      IX_HGT:                       rdc = hgt_q;
      IX_MAXW:                      rdc = 32'(MAX_W);
      IX_MAXH:                      rdc = 32'(MAX_H);
      IX_DEPTH:                     rdc = 32'(COLOR_DEPTH);
      IX_BPP, IX_HOSTBPP:           rdc = BPP_RND;
      IX_RMASK:                     rdc = red_mask(COLOR_DEPTH);
      IX_GMASK:                     rdc = green_mask(COLOR_DEPTH);
      IX_BMASK:                     rdc = blue_mask(COLOR_DEPTH);
      IX_PITCH:                     rdc = pitch;
      IX_FBSIZE:                    rdc = fb_q;
      IX_CAPS:                      rdc = CAPS;
      IX_CFG:                       rdc = {31'b0, cfg_q};
      IX_SYNC, IX_BUSY:             rdc = {31'b0, busy_q};
      IX_CUR_ID:                    rdc = cur_id_q;
      IX_CUR_X:                     rdc = cur_x_q;
      IX_CUR_Y:                     rdc = cur_y_q;
      IX_CUR_ON:                    rdc = {31'b0, vis_q};
      IX_SCRSZ:                     rdc = 32'(SCRATCH_N);
      IX_PSEUDO, IX_MEMREGS,
      IX_NDISP, IX_PLOCK:           rdc = '0;
      default: known = in_scr || ((idx_q >= IX_PAL_LO) && (idx_q <= IX_PAL_HI));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;      ver_q <= VER_TOP;   en_q <= '0;
      wid_q <= '0;      hgt_q <= '0;        fb_q <= '0;
      cfg_q <= 1'b0;    busy_q <= 1'b0;     vis_q <= 1'b0;
      cur_id_q <= '0;   cur_x_q <= '0;      cur_y_q <= '0;
      inval_q <= 1'b0;  sync_q <= 1'b0;     cupd_q <= 1'b0;
      bad_q <= 1'b0;    rsp_v_q <= 1'b0;    rsp_scr_q <= 1'b0;
      rsp_buf_q <= '0;
    end else begin
      inval_q   <= 1'b0;
      sync_q    <= 1'b0;
      cupd_q    <= 1'b0;
      rsp_v_q   <= rd_val | rd_idx;
      rsp_scr_q <= rd_val & in_scr;
      rsp_buf_q <= rd_idx ? idx_q : rdc;
      bad_q     <= (rd_val | wr_val) & ~known;
      if (sync_done) busy_q <= 1'b0;
      if (wr_idx) idx_q <= req_wdata;
      if (wr_val) begin
        case (idx_q)
          IX_VER: if (req_wdata >= VER_BASE && req_wdata <= VER_TOP) ver_q <= req_wdata;
          IX_EN: begin
            en_q    <= req_wdata;
            inval_q <= 1'b1;
            if (req_wdata == '0) cfg_q <= 1'b0;
            else fb_q <= pitch * hgt_q;
          end
          IX_WID: begin wid_q <= req_wdata; inval_q <= 1'b1; end
          IX_HGT: begin hgt_q <= req_wdata; inval_q <= 1'b1; end
          IX_DEPTH, IX_BPP: if (req_wdata != 32'(COLOR_DEPTH)) cfg_q <= 1'b0;
          IX_CFG: begin
            if (req_wdata == '0) cfg_q <= 1'b0;
            else if (q_ok)       cfg_q <= 1'b1;
          end
          IX_SYNC: begin busy_q <= 1'b1; sync_q <= 1'b1; end
          IX_CUR_ID: cur_id_q <= req_wdata;
          IX_CUR_X:  cur_x_q  <= req_wdata;
          IX_CUR_Y:  cur_y_q  <= req_wdata;
          IX_CUR_ON: begin
            if (req_wdata == 32'd1) begin vis_q <= 1'b1; cupd_q <= 1'b1; end
            if (req_wdata == 32'd0) begin vis_q <= 1'b0; cupd_q <= 1'b1; end
          end
          default: ;
        endcase
      end
    end
  end

  assign req_ready    = 1'b1;
  assign rsp_valid    = rsp_v_q;
  assign rsp_rdata    = rsp_scr_q ? scr_rd : rsp_buf_q;
  assign enable_o     = |en_q;
  assign cfg_valid_o  = cfg_q;
  assign invalidate_o = inval_q;
  assign sync_req_o   = sync_q;
  assign cursor_vis_o = vis_q;
  assign cursor_upd_o = cupd_q;
  assign cursor_x_o   = cur_x_q;
  assign cursor_y_o   = cur_y_q;
  assign fb_size_o    = fb_q;
  assign bad_access_o = bad_q;
endmodule

// File: rtl/dispctl_regport_chk.sv
module dispctl_regport_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_sel,
  input logic [31:0] req_wdata,
  input logic [31:0] idx,
  input logic        rsp_valid,
  input logic        enable_o,
  input logic        cfg_valid_o,
  input logic        invalidate_o,
  input logic        sync_req_o,
  input logic        cursor_vis_o,
  input logic        cursor_upd_o
);
  logic vwr;
  assign vwr = req_valid & req_write & req_sel;

  // R1
  a_r1_read_latency: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);
  // R1
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);
  // R3
  a_r3_disable_drops_cfg: assert property (@(posedge clk) disable iff (rst)
    (vwr && idx == 32'd1 && req_wdata == 32'd0) |=> (!cfg_valid_o && !enable_o && invalidate_o));
  // R8
  a_r8_cfg_rise_source: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_valid_o) |-> $past(vwr && idx == 32'd20 && req_wdata != 32'd0));
  // R9
  a_r9_sync_pulse: assert property (@(posedge clk) disable iff (rst)
    (vwr && idx == 32'd21) |=> sync_req_o);
  // R10
  a_r10_upd_source: assert property (@(posedge clk) disable iff (rst)
    cursor_upd_o |-> $past(vwr && idx == 32'd27 && req_wdata <= 32'd1));
  // R10
  a_r10_vis_change_pulses: assert property (@(posedge clk) disable iff (rst)
    ($rose(cursor_vis_o) || $fell(cursor_vis_o)) |-> cursor_upd_o);
endmodule

bind dispctl_regport dispctl_regport_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_sel(req_sel), .req_wdata(req_wdata), .idx(idx_q), .rsp_valid(rsp_valid),
  .enable_o(enable_o), .cfg_valid_o(cfg_valid_o), .invalidate_o(invalidate_o),
  .sync_req_o(sync_req_o), .cursor_vis_o(cursor_vis_o), .cursor_upd_o(cursor_upd_o)
);

// File: tb/sim_dispctl_regport.sv
module sim_dispctl_regport;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] q_lo = 32'd16, q_hi = 32'd10256, q_next = 32'd16, q_stop = 32'd16;
  logic        sync_done = 1'b0;
  logic        enable_o, cfg_valid_o, invalidate_o, sync_req_o;
  logic        cursor_vis_o, cursor_upd_o, bad_access_o;
  logic [31:0] cursor_x_o, cursor_y_o, fb_size_o;

  int compared = 0, mismatched = 0, cycles = 0;
  logic p_inv, p_sync, p_upd, p_bad;

  logic [31:0] exp_d[$];
  logic        exp_b[$];
  string       exp_t[$];

  always #5 clk = ~clk;

  dispctl_regport u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .q_lo(q_lo), .q_hi(q_hi), .q_next(q_next), .q_stop(q_stop),
    .sync_done(sync_done), .enable_o(enable_o), .cfg_valid_o(cfg_valid_o),
    .invalidate_o(invalidate_o), .sync_req_o(sync_req_o),
    .cursor_vis_o(cursor_vis_o), .cursor_upd_o(cursor_upd_o),
    .cursor_x_o(cursor_x_o), .cursor_y_o(cursor_y_o),
    .fb_size_o(fb_size_o), .bad_access_o(bad_access_o)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_d.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R1 unexpected response actual=0x%08h expected=none", rsp_rdata);
      end else begin
        automatic logic [31:0] d = exp_d.pop_front();
        automatic logic        b = exp_b.pop_front();
        automatic string       t = exp_t.pop_front();
        check(rsp_rdata == d, t, rsp_rdata, d);
        check(bad_access_o == b, {t, " bad_access"}, {31'b0, bad_access_o}, {31'b0, b});
      end
    end
  end

  task automatic port_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    p_inv = invalidate_o; p_sync = sync_req_o; p_upd = cursor_upd_o; p_bad = bad_access_o;
  endtask

  task automatic wr_reg(input logic [31:0] ix, input logic [31:0] d);
    port_wr(1'b0, ix);
    port_wr(1'b1, d);
  endtask

  task automatic rd_port(input logic sel, input logic [31:0] exp, input logic bad, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = sel;
    exp_d.push_back(exp); exp_b.push_back(bad); exp_t.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_reg(input logic [31:0] ix, input logic [31:0] exp, input logic bad, input string tag);
    port_wr(1'b0, ix);
    rd_port(1'b1, exp, bad, tag);
  endtask

  task automatic cfg_try(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] st,
                         input logic exp, input string tag);
    q_lo = lo; q_hi = hi; q_stop = st;
    wr_reg(32'd20, 32'd1);
    check(cfg_valid_o == exp, tag, {31'b0, cfg_valid_o}, {31'b0, exp});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state
    check(!enable_o && !cfg_valid_o && !cursor_vis_o && !bad_access_o, "R3 reset outputs",
          {28'b0, enable_o, cfg_valid_o, cursor_vis_o, bad_access_o}, 32'd0);
    check(req_ready == 1'b1, "R1 ready", {31'b0, req_ready}, 32'd1);
    rd_port(1'b0, 32'd0, 1'b0, "R1 index reset");
    rd_reg(32'd0, 32'h9000_0002, 1'b0, "R2 version reset");
    port_wr(1'b0, 32'd1234);
    rd_port(1'b0, 32'd1234, 1'b0, "R1 index readback");

    // R2 version code filter
    wr_reg(32'd0, 32'h9000_0000);
    rd_reg(32'd0, 32'h9000_0000, 1'b0, "R2 legal code 0");
    wr_reg(32'd0, 32'h1234_5678);
    rd_reg(32'd0, 32'h9000_0000, 1'b0, "R2 illegal ignored");
    wr_reg(32'd0, 32'h9000_0003);
    rd_reg(32'd0, 32'h9000_0000, 1'b0, "R2 code 3 ignored");
    wr_reg(32'd0, 32'h9000_0001);
    rd_reg(32'd0, 32'h9000_0001, 1'b0, "R2 legal code 1");

    // R6 constants
    rd_reg(32'd4, 32'd2360, 1'b0, "R6 max width");
    rd_reg(32'd5, 32'd1770, 1'b0, "R6 max height");
    rd_reg(32'd6, 32'd32, 1'b0, "R6 depth");
    rd_reg(32'd7, 32'd32, 1'b0, "R6 bpp");
    rd_reg(32'd28, 32'd32, 1'b0, "R6 host bpp");
    rd_reg(32'd9, 32'h00FF_0000, 1'b0, "R6 red mask");
    rd_reg(32'd10, 32'h0000_FF00, 1'b0, "R6 green mask");
    rd_reg(32'd11, 32'h0000_00FF, 1'b0, "R6 blue mask");
    rd_reg(32'd17, 32'h3, 1'b0, "R6 caps");
    rd_reg(32'd29, 32'd16, 1'b0, "R6 scratch size");
    wr_reg(32'd4, 32'd5);
    rd_reg(32'd4, 32'd2360, 1'b0, "R6 write ignored");

    // R5 mode size
    wr_reg(32'd2, 32'd640);
    check(p_inv, "R5 width invalidate", {31'b0, p_inv}, 32'd1);
    wr_reg(32'd3, 32'd480);
    check(p_inv, "R5 height invalidate", {31'b0, p_inv}, 32'd1);
    rd_reg(32'd2, 32'd640, 1'b0, "R5 width");
    rd_reg(32'd3, 32'd480, 1'b0, "R5 height");
    rd_reg(32'd12, 32'd2560, 1'b0, "R5 pitch");

    // R4 / R3 enable
    wr_reg(32'd1, 32'd1);
    check(enable_o && p_inv, "R3 enable+invalidate", {30'b0, enable_o, p_inv}, 32'd3);
    check(fb_size_o == 32'd1228800, "R4 fb size pin", fb_size_o, 32'd1228800);
    rd_reg(32'd16, 32'd1228800, 1'b0, "R4 fb size read");

    // R8 configuration validation
    cfg_try(32'd16, 32'd10256, 32'd16, 1'b1, "R8 legal minimum span");
    cfg_try(32'd16, 32'h10004, 32'd16, 1'b1, "R8 failed commit keeps flag");
    wr_reg(32'd20, 32'd0);
    check(!cfg_valid_o, "R8 zero clears", {31'b0, cfg_valid_o}, 32'd0);
    cfg_try(32'd12, 32'd20000, 32'd16, 1'b0, "R8 lower bound too small");
    cfg_try(32'd16, 32'h10004, 32'd16, 1'b0, "R8 upper bound too large");
    cfg_try(32'd16, 32'd10252, 32'd16, 1'b0, "R8 span short");
    cfg_try(32'd16, 32'd20000, 32'd18, 1'b0, "R8 misaligned stop");
    cfg_try(32'd16, 32'h10000, 32'd16, 1'b1, "R8 upper bound exact");
    rd_reg(32'd20, 32'd1, 1'b0, "R8 flag readback");

    // R7 depth writes
    wr_reg(32'd6, 32'd32);
    check(cfg_valid_o, "R7 matching depth", {31'b0, cfg_valid_o}, 32'd1);
    wr_reg(32'd7, 32'd24);
    check(!cfg_valid_o, "R7 mismatched depth", {31'b0, cfg_valid_o}, 32'd0);

    // R3 enable value and disable
    wr_reg(32'd20, 32'd1);
    wr_reg(32'd1, 32'd5);
    check(cfg_valid_o && enable_o, "R3 nonzero keeps cfg", {30'b0, cfg_valid_o, enable_o}, 32'd3);
    rd_reg(32'd1, 32'd5, 1'b0, "R3 enable readback");
    wr_reg(32'd1, 32'd0);
    check(!cfg_valid_o && !enable_o && p_inv, "R3 disable",
          {29'b0, cfg_valid_o, enable_o, p_inv}, 32'd1);

    // R9 sync
    wr_reg(32'd21, 32'd1);
    check(p_sync, "R9 sync pulse", {31'b0, p_sync}, 32'd1);
    rd_reg(32'd22, 32'd1, 1'b0, "R9 busy set");
    rd_reg(32'd21, 32'd1, 1'b0, "R9 sync reads busy");
    @(negedge clk); sync_done = 1'b1;
    @(negedge clk); sync_done = 1'b0;
    rd_reg(32'd22, 32'd0, 1'b0, "R9 busy cleared");

    // R10 cursor
    wr_reg(32'd24, 32'd7);
    wr_reg(32'd25, 32'd100);
    wr_reg(32'd26, 32'd200);
    rd_reg(32'd24, 32'd7, 1'b0, "R10 cursor id");
    rd_reg(32'd25, 32'd100, 1'b0, "R10 cursor x");
    rd_reg(32'd26, 32'd200, 1'b0, "R10 cursor y");
    check(cursor_x_o == 32'd100 && cursor_y_o == 32'd200, "R10 cursor pins", cursor_y_o, 32'd200);
    wr_reg(32'd27, 32'd1);
    check(cursor_vis_o && p_upd, "R10 show", {30'b0, cursor_vis_o, p_upd}, 32'd3);
    wr_reg(32'd27, 32'd2);
    check(cursor_vis_o && !p_upd, "R10 code 2 after show", {30'b0, cursor_vis_o, p_upd}, 32'd2);
    wr_reg(32'd27, 32'd0);
    check(!cursor_vis_o && p_upd, "R10 hide", {30'b0, cursor_vis_o, p_upd}, 32'd1);
    wr_reg(32'd27, 32'd3);
    check(!cursor_vis_o && !p_upd, "R10 code 3 after hide", {30'b0, cursor_vis_o, p_upd}, 32'd0);
    rd_reg(32'd27, 32'd0, 1'b0, "R10 visibility read");

    // R11 scratch
    wr_reg(32'd1792, 32'hA5A5_5A5A);
    wr_reg(32'd1807, 32'h0000_1234);
    rd_reg(32'd1792, 32'hA5A5_5A5A, 1'b0, "R11 scratch first");
    rd_reg(32'd1807, 32'h0000_1234, 1'b0, "R11 scratch last");
    rd_reg(32'd1808, 32'd0, 1'b1, "R11 past end is unmapped");

    // R12 silent and unmapped indices
    wr_reg(32'd1100, 32'hFFFF_FFFF);
    check(!p_bad, "R12 palette write silent", {31'b0, p_bad}, 32'd0);
    rd_reg(32'd1100, 32'd0, 1'b0, "R12 palette reads zero");
    rd_reg(32'd30, 32'd0, 1'b0, "R12 reserved reads zero");
    rd_reg(32'd8, 32'd0, 1'b0, "R12 pseudo reads zero");
    rd_reg(32'd13, 32'd0, 1'b1, "R12 unmapped read");
    wr_reg(32'd13, 32'd9);
    check(p_bad, "R12 unmapped write", {31'b0, p_bad}, 32'd1);

    repeat (3) @(negedge clk);
    check(exp_d.size() == 0, "R1 all responses seen", exp_d.size(), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule